// File: doc/BRIEF.md
# Sleep Wake-Up Countdown Timer

This block counts down from a software-programmed value on a slow always-on time base, a strobe derived from a 32.768 kHz oscillator, and raises a sticky interrupt flag when the count runs out. Its purpose is to wake a system from deep sleep after a chosen interval. Software can also read the remaining count after waking, which shows how much of the interval actually passed.

Software works through a simple register port with four word addresses. A control register carries a single resolution bit. At fine resolution the counter steps once per strobe, about 30.5 us per count. At coarse resolution it steps once every 4096 strobes, 0.125 s per count. The counter is 16 bits wide, so one interval can last up to about 2 s at fine resolution or about 2.27 h at coarse resolution. Writing the preload register arms the timer, except that writing zero switches it off. The status register holds the wake flag, and software clears the flag by writing a one to it.

Top module: `wkt_wake_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0, the preload register reads 0, the wake flag is 0 and the timer is stopped.
- R2: The registers sit at these word addresses: 0 is control (bit 0 selects resolution), 1 is preload, 2 is the current count (read-only), and 3 is status (bit 0 is the wake flag). Writing a nonzero value to preload loads the count with that value on the next clock and starts the timer. Preload reads back the last value written to it.
- R3: When control bit 0 is 0, a running timer decrements the count by one on each clock cycle in which the strobe input is high.
- R4: When control bit 0 is 1, a running timer decrements once per 4096 strobes. Any write to control or to preload restarts this strobe tally from zero, so the first decrement after such a write comes on the 4096th strobe that follows it.
- R5: The clock edge that brings the count from 1 to 0 sets the wake flag. The timer then stops and holds the count at 0, whatever the strobe does, until preload is written again.
- R6: Writing 0 to preload stops the timer and sets the count to 0 without setting the wake flag. Later strobes leave both unchanged.
- R7: Writing status with bit 0 set clears the wake flag. Writing status with bit 0 clear leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R8: The irq output equals the wake flag. Strobes that arrive while the timer is stopped change neither the count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every register updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe at the always-on time-base rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at addr (combinational) |
| irq | output | 1 | Sticky wake interrupt flag |

## Verification
The assertions assume that tick_en is high for single, separate cycles, the way a pulse synchronised from the slow oscillator behaves, and that a write affects only the one addressed register. They do not assume any particular strobe rate or any spacing between writes. The stimulus therefore raises the strobe at random densities, sometimes on consecutive cycles. It mixes random writes to all four addresses, including zero preloads and status writes with bit 0 clear. Coarse resolution is paired with small preloads so that expiries fall inside the run.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

   typedef enum logic [1:0] {
      WKT_CTRL  = 2'd0,
      WKT_LOAD  = 2'd1,
      WKT_COUNT = 2'd2,
      WKT_STAT  = 2'd3
   } wkt_reg_e;

   localparam int WKT_SEL_BIT  = 0;
   localparam int WKT_FLAG_BIT = 0;

endpackage

// File: rtl/wkt_prescale.sv
module wkt_prescale #(
   parameter int SHIFT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic coarse,
   input  logic strobe,
   output logic tick
);

   initial assert (SHIFT >= 0 && SHIFT <= 24) else $error("wkt_prescale: SHIFT out of range");

   generate
      if (SHIFT == 0) begin : g_bypass
         assign tick = run & strobe & ~restart;
      end else begin : g_div
         localparam logic [SHIFT-1:0] LAST = {SHIFT{1'b1}};
         logic [SHIFT-1:0] tally;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tally <= '0;
            else if (restart)
               tally <= '0;
            else if (run && strobe && coarse)
               tally <= tally + 1'b1;
         end

         assign tick = run & strobe & ~restart & (~coarse | (tally == LAST));

         p_tick_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tick |-> (strobe && run));
         p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (tally == '0));
      end
   endgenerate

endmodule

// File: rtl/wkt_down.sv
module wkt_down #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic [W-1:0] count,
   output logic         running,
   output logic         expire
);

   initial assert (W >= 2 && W <= 32) else $error("wkt_down: W out of range");

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   assign expire = tick & running & ~load & (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
      end else if (load) begin
         count   <= load_val;
         running <= (load_val != '0);
      end else if (tick && running) begin
         count <= count - ONE;
         if (count == ONE)
            running <= 1'b0;
      end
   end

   p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && running && !load) |=> (count == $past(count) - ONE));
   p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !load) |=> ($stable(count) && !running));
   p_stop_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (!running && count == '0));
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));

endmodule

// File: rtl/wkt_flag.sv
module wkt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else
         flag <= set | (flag & ~clr);
   end

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

endmodule

// File: rtl/wkt_wake_timer.sv
module wkt_wake_timer #(
   parameter int CNT_W     = 16,
   parameter int PRE_SHIFT = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq
);
   import wkt_pkg::*;

   initial assert (CNT_W >= 2) else $error("wkt_wake_timer: CNT_W too small");

   localparam logic [CNT_W-1:0] ZERO = '0;

   logic             wr_ctrl, wr_load, wr_stat;
   logic             coarse_q;
   logic [CNT_W-1:0] preload_q;
   logic             tick, running, expire, flag;
   logic [CNT_W-1:0] count;

   assign wr_ctrl = wr_en && (addr == WKT_CTRL);
   assign wr_load = wr_en && (addr == WKT_LOAD);
   assign wr_stat = wr_en && (addr == WKT_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q  <= 1'b0;
         preload_q <= '0;
      end else begin
         if (wr_ctrl)
            coarse_q <= wdata[WKT_SEL_BIT];
         if (wr_load)
            preload_q <= wdata;
      end
   end

   wkt_prescale #(.SHIFT(PRE_SHIFT)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_ctrl | wr_load),
      .run     (running),
      .coarse  (coarse_q),
      .strobe  (tick_en),
      .tick    (tick)
   );

   wkt_down #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_load),
      .load_val (wdata),
      .tick     (tick),
      .count    (count),
      .running  (running),
      .expire   (expire)
   );

   wkt_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire),
      .clr   (wr_stat & wdata[WKT_FLAG_BIT]),
      .flag  (flag)
   );

   always_comb begin
      rdata = ZERO;
      case (addr)
         WKT_CTRL:  rdata[WKT_SEL_BIT]  = coarse_q;
         WKT_LOAD:  rdata               = preload_q;
         WKT_COUNT: rdata               = count;
         default:   rdata[WKT_FLAG_BIT] = flag;
      endcase
   end

   assign irq = flag;

   p_zero_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_load && wdata == ZERO) |=> (!running && count == ZERO && !($rose(flag))));
   p_idle_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !flag) |=> !flag);

endmodule

// File: tb/wkt_wake_timer_test.sv
module wkt_wake_timer_test;

   localparam int W = 16;
   localparam int DIV = 4096;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   addr = 2'd2;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq;

   int total = 0;
   int bad = 0;

   // reference state
   int  m_cnt = 0, m_pre = 0, m_load = 0;
   bit  m_run = 0, m_div = 0, m_flag = 0;

   always #5 clk = ~clk;

   wkt_wake_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic bit ref_tick(bit run, bit st, bit restart, bit dv, int pre);
      return run && st && !restart && (!dv || pre == DIV - 1);
   endfunction

   task automatic model(bit wr, int a, int d, bit st);
      bit restart, tk, ex, ld;
      restart = wr && (a == 0 || a == 1);
      ld = wr && a == 1;
      tk = ref_tick(m_run, st, restart, m_div, m_pre);
      ex = tk && !ld && m_cnt == 1;
      if (restart) m_pre = 0;
      else if (m_run && st && m_div) m_pre = (m_pre + 1) % DIV;
      if (ld) begin
         m_cnt = d; m_run = (d != 0); m_load = d;
      end else if (tk) begin
         if (m_cnt == 1) m_run = 0;
         m_cnt = m_cnt - 1;
      end
      if (wr && a == 0) m_div = d[0];
      m_flag = ex || (m_flag && !(wr && a == 3 && d[0]));
   endtask

   // called at a falling edge, returns at the next falling edge
   task automatic step(bit wr, int a, int d, bit st);
      wr_en = wr; addr = a[1:0]; wdata = d[W-1:0]; tick_en = st;
      @(posedge clk);
      model(wr, a, d, st);
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
   endtask

   task automatic strobes(int n);
      for (int i = 0; i < n; i++) step(0, 2, 0, 1);
   endtask

   task automatic chk_reg(int a, int exp, string tag);
      addr = a[1:0];
      #1;
      total++;
      if (rdata !== exp[W-1:0]) begin
         bad++;
         $display("FAIL %s: reg %0d actual=%0d expected=%0d", tag, a, rdata, exp);
      end
   endtask

   task automatic chk_irq(bit exp, string tag);
      #1;
      total++;
      if (irq !== exp) begin
         bad++;
         $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_reg(2, 0, "R1 count");
      chk_reg(0, 0, "R1 ctrl");
      chk_reg(1, 0, "R1 preload");
      chk_reg(3, 0, "R1 status");
      chk_irq(0, "R1 irq");

      // R8 strobes while stopped
      strobes(5);
      chk_reg(2, 0, "R8 idle count");
      chk_irq(0, "R8 idle irq");

      // R2/R3/R5 fine resolution
      step(1, 1, 5, 0);
      chk_reg(2, 5, "R2 load");
      chk_reg(1, 5, "R2 preload readback");
      strobes(2);
      chk_reg(2, 3, "R3 two strobes");
      step(0, 2, 0, 0); step(0, 2, 0, 0);
      chk_reg(2, 3, "R3 no strobe hold");
      strobes(2);
      chk_irq(0, "R5 before expiry");
      strobes(1);
      chk_reg(2, 0, "R5 expired count");
      chk_irq(1, "R5 expiry irq");
      strobes(4);
      chk_reg(2, 0, "R5 hold at zero");

      // R7 write-one-to-clear
      step(1, 3, 0, 0);
      chk_irq(1, "R7 write zero keeps flag");
      step(1, 3, 1, 0);
      chk_irq(0, "R7 write one clears");

      // R6 zero preload disables
      step(1, 1, 7, 0);
      strobes(2);
      chk_reg(2, 5, "R6 running");
      step(1, 1, 0, 0);
      chk_reg(2, 0, "R6 zero write");
      strobes(10);
      chk_reg(2, 0, "R6 stays off");
      chk_irq(0, "R6 no flag");

      // R7 set beats clear in the same cycle
      step(1, 1, 1, 0);
      step(1, 3, 1, 1);
      chk_irq(1, "R7 set wins");
      step(1, 3, 1, 0);

      // R4 coarse resolution with restart
      step(1, 0, 1, 0);
      chk_reg(0, 1, "R4 ctrl readback");
      step(1, 1, 2, 0);
      strobes(100);
      step(1, 0, 1, 0);
      strobes(DIV - 1);
      chk_reg(2, 2, "R4 restart delays step");
      strobes(1);
      chk_reg(2, 1, "R4 first coarse step");
      strobes(DIV - 1);
      chk_irq(0, "R4 not yet expired");
      strobes(1);
      chk_reg(2, 0, "R4 coarse expiry count");
      chk_irq(1, "R4 coarse expiry irq");
      step(1, 3, 1, 0);
      step(1, 0, 0, 0);

      // random mix, reference compared every cycle (R3 R5 R6 R7 R8)
      for (int i = 0; i < 4000; i++) begin
         int r, a, d;
         bit wr, st;
         r = $urandom_range(0, 99);
         st = ($urandom_range(0, 2) != 0);
         wr = (r < 12);
         a = $urandom_range(0, 3);
         d = $urandom_range(0, 40);
         if (wr && a == 0) d = ($urandom_range(0, 9) == 0) ? 1 : 0;
         if (wr && a == 1 && m_div) d = $urandom_range(0, 2);
         if (wr && a == 3) d = $urandom_range(0, 1);
         step(wr, a, d, st);
         chk_reg(2, m_cnt, "R3 random count");
         chk_irq(m_flag, "R5 random irq");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule